// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits on the host side of a synchronous memory interface and runs fixed-length burst reads. Software sets a small control register. A start pulse then pulls the active-low chip enable low. The block counts interface clocks through the first-word latency and captures one data word per beat, with each beat lasting one or two clocks. After a programmed number of trailing clocks it releases chip enable. Captured words leave on a valid/data pair. A single-cycle done strobe marks the release.

The interface clock can be paused. The block runs on the system clock, and `clk_en` marks which rising edges are interface clock edges. Only enabled edges move the sequencer. Paused cycles freeze it completely.

States: `ST_IDLE`, `ST_LAT`, `ST_DATA`, `ST_TAIL`. Transitions:
- *accept*: `ST_IDLE`→`ST_LAT` on an enabled edge with `start` high.
- *first word*: `ST_LAT`→`ST_DATA` when the latency count expires.
- *next beat*: `ST_DATA`→`ST_DATA` while words remain.
- *last word*: `ST_DATA`→`ST_TAIL` on the final capture.
- *release*: `ST_TAIL`→`ST_IDLE` when the trailing count expires.

Top module: `burst_rd_ctrl`

## Requirements
- R1: A burst is accepted only on a rising edge where `clk_en` is high, `start` is high and the block is idle. `ce_n` falls in the cycle after that edge. `start` has no effect while a burst is running.
- R2: Control register layout, with `cfg_wr` writing `cfg_wdata` on any clock edge whether `clk_en` is high or low:
  - bits [2:0]: latency value L;
  - bits [4:3]: trailing value W;
  - bit [5]: hold flag H;
  - bits [7:6]: length code C.
- R3: The first word is captured on the (L+4)-th enabled edge after the accepting edge. That is 3+L enabled edges after the edge on which the device first sees `ce_n` low. `out_valid` is high for the one cycle after a capture edge, and `out_data` then equals `rd_data` as sampled on that edge.
- R4: With H=0, words are captured on consecutive enabled edges. With H=1, each word occupies two enabled edges and is captured on the first of them, so successive captures are two enabled edges apart.
- R5: Length code C selects 4, 8, 16 or 32 words (4 shifted left by C). Every burst delivers exactly that many `out_valid` pulses, all while `ce_n` is low.
- R6: `ce_n` returns high on the W-th enabled edge after the last capture edge. W=0 is treated as 1.
- R7: `done` is high for exactly the one cycle in which `ce_n` has just returned high, and at no other time.
- R8: On a cycle whose edge has `clk_en` low, no count advances. No capture, release or acceptance happens on that edge.
- R9: The register is snapshotted on the accepting edge, and the snapshot takes the value held before any write on that same edge. Writes made during a burst affect only later bursts.
- R10: `busy` is high exactly while `ce_n` is low.
- R11: After reset, `ce_n` is high and `busy`, `out_valid` and `done` are low. The register resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; its rising edges carry the interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | High when the current edge is an interface clock edge |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| start | input | 1 | Burst request, taken only when idle |
| rd_data | input | DATA_W | Data bus from the memory device |
| ce_n | output | 1 | Active-low chip enable to the device |
| busy | output | 1 | Burst in progress |
| out_valid | output | 1 | One-cycle strobe marking a captured word |
| out_data | output | DATA_W | Captured word |
| done | output | 1 | One-cycle strobe on chip-enable release |

## Verification
The bench drives two same-edge collisions and compares each against a schedule-based reference model on every clock.

The first collision is a register write on the very edge that accepts a burst. The bench checks that the burst's word count and timing follow the old value, and that the following burst follows the new one.

The second is a request held high through the release cycle. The bench checks that `start` is ignored on the release edge and that the next burst is accepted on the edge right after `done`.

Paused-clock phases randomise `clk_en` so that pauses land on latency, hold, capture and trailing edges alike.

// File: rtl/bctl_pkg.sv
package bctl_pkg;

    parameter int unsigned LAT_W = 3;
    parameter int unsigned WS_W  = 2;
    parameter int unsigned LEN_W = 2;

    localparam int unsigned CFG_W     = LEN_W + 1 + WS_W + LAT_W;
    localparam int unsigned BASE_LAT  = 3;
    localparam int unsigned MIN_WORDS = 4;
    localparam int unsigned MAX_WORDS = MIN_WORDS << ((1 << LEN_W) - 1);
    localparam int unsigned MAX_LAT   = BASE_LAT + (1 << LAT_W) - 1;
    localparam int unsigned CNT_MAX   = (MAX_WORDS > MAX_LAT) ? MAX_WORDS : MAX_LAT;
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             hold;
        logic [WS_W-1:0]  ws;
        logic [LAT_W-1:0] lat;
    } bctl_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_DATA,
        ST_TAIL
    } bctl_state_e;

endpackage

// File: rtl/bctl_cfg_reg.sv
module bctl_cfg_reg
    import bctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             load,
    output bctl_cfg_t        snap
);

    bctl_cfg_t live_q;
    bctl_cfg_t snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (wr) begin
            live_q <= bctl_cfg_t'(wdata);
        end
    end

    // Nonblocking read of live_q: a write on the accepting edge is not seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (load) begin
            snap_q <= live_q;
        end
    end

    assign snap = snap_q;

endmodule

// File: rtl/bctl_fsm.sv
module bctl_fsm
    import bctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clk_en,
    input  logic      start,
    input  bctl_cfg_t cfg,
    output logic      accept,
    output logic      capture,
    output logic      ce_n,
    output logic      done
);

    bctl_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] words_q, words_d;
    logic             skip_q, skip_d;
    logic             release_w;

    logic [CNT_W-1:0] lat_last;
    logic [CNT_W-1:0] word_total;
    logic [CNT_W-1:0] tail_last;

    assign lat_last   = CNT_W'(cfg.lat) + CNT_W'(BASE_LAT);
    assign word_total = CNT_W'(MIN_WORDS) << cfg.len;
    assign tail_last  = (cfg.ws == '0) ? '0 : (CNT_W'(cfg.ws) - CNT_W'(1));

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        words_d   = words_q;
        skip_d    = skip_q;
        accept    = 1'b0;
        capture   = 1'b0;
        release_w = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (clk_en && start) begin
                    accept  = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_LAT;
                end
            end
            ST_LAT: begin
                if (clk_en) begin
                    if (cnt_q == lat_last) begin
                        capture = 1'b1;
                        words_d = CNT_W'(1);
                        skip_d  = cfg.hold;
                        state_d = ST_DATA;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (clk_en) begin
                    if (skip_q) begin
                        skip_d = 1'b0;
                    end else begin
                        capture = 1'b1;
                        words_d = words_q + CNT_W'(1);
                        skip_d  = cfg.hold;
                        if (words_q == word_total - CNT_W'(1)) begin
                            cnt_d   = '0;
                            state_d = ST_TAIL;
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (clk_en) begin
                    if (cnt_q == tail_last) begin
                        release_w = 1'b1;
                        state_d   = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            words_q <= '0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            words_q <= words_d;
            skip_q  <= skip_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n <= 1'b1;
            done <= 1'b0;
        end else begin
            ce_n <= (state_d == ST_IDLE);
            done <= release_w;
        end
    end

endmodule

// File: rtl/bctl_capture.sv
module bctl_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= capture;
            if (capture) begin
                out_data <= rd_data;
            end
        end
    end

endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
    import bctl_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              start,
    input  logic [DATA_W-1:0] rd_data,
    output logic              ce_n,
    output logic              busy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);

    bctl_cfg_t cfg_snap;
    logic      accept;
    logic      capture;
    logic      snap_hold;

    bctl_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .load  (accept),
        .snap  (cfg_snap)
    );

    bctl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .start   (start),
        .cfg     (cfg_snap),
        .accept  (accept),
        .capture (capture),
        .ce_n    (ce_n),
        .done    (done)
    );

    bctl_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .rd_data   (rd_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign busy      = ~ce_n;
    assign snap_hold = cfg_snap.hold;

endmodule

// File: rtl/burst_rd_ctrl_chk.sv
module burst_rd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic start,
    input logic ce_n,
    input logic busy,
    input logic out_valid,
    input logic done,
    input logic snap_hold
);

    logic [6:0] vcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (done) begin
            vcnt <= '0;
        end else if (out_valid) begin
            vcnt <= vcnt + 7'd1;
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> ($past(start) && $past(clk_en)));

    p_hold_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && snap_hold) |=> !out_valid);

    p_valid_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!ce_n && busy));

    p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(vcnt) == 1 && vcnt >= 7'd4 && vcnt <= 7'd32));

    p_release_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |-> done);

    p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(ce_n) && !busy));

    p_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clk_en) |-> (!out_valid && !done && $stable(ce_n)));

endmodule

bind burst_rd_ctrl burst_rd_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .start     (start),
    .ce_n      (ce_n),
    .busy      (busy),
    .out_valid (out_valid),
    .done      (done),
    .snap_hold (snap_hold)
);

// File: tb/sim_burst_rd_ctrl.sv
module sim_burst_rd_ctrl;
    import bctl_pkg::*;

    localparam int DW = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic             start = 1'b0;
    logic [DW-1:0]    rd_data = '0;
    logic             ce_n, busy, out_valid, done;
    logic [DW-1:0]    out_data;

    int    errors = 0;
    int    checks = 0;
    string tag = "R11";
    bit    pause_mode = 1'b0;
    bit    running = 1'b0;

    // reference model state (schedule based)
    bit          m_busy = 0, m_ce = 1, m_valid = 0, m_done = 0;
    logic [DW-1:0] m_data = '0;
    int          live = 0, old_live;
    int          e, k, s_n, first, step, rel, vc = 0;

    burst_rd_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .start(start), .rd_data(rd_data),
        .ce_n(ce_n), .busy(busy), .out_valid(out_valid),
        .out_data(out_data), .done(done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) act=%0d exp=%0d t=%0t", req, tag, act, exp, $time);
        end
    endtask

    function automatic logic [CFG_W-1:0] mk(input int lat, input int ws, input int hold, input int len);
        mk = {2'(len), 1'(hold), 2'(ws), 3'(lat)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_ce = 1; m_valid = 0; m_done = 0; live = 0;
        end else begin
            old_live = live;
            m_valid = 0;
            m_done  = 0;
            if (clk_en) begin
                if (m_busy) begin
                    e++;
                    if (k < s_n && e == first + k * step) begin
                        m_valid = 1;
                        m_data  = rd_data;
                        k++;
                    end
                    if (k == s_n && e == rel) begin
                        m_busy = 0; m_ce = 1; m_done = 1;
                    end
                end else if (start) begin
                    m_busy = 1; m_ce = 0; e = 0; k = 0;
                    s_n   = 4 << ((old_live >> 6) & 3);
                    first = (old_live & 7) + 4;
                    step  = ((old_live >> 5) & 1) ? 2 : 1;
                    rel   = first + (s_n - 1) * step
                            + ((((old_live >> 3) & 3) == 0) ? 1 : ((old_live >> 3) & 3));
                end
            end
            if (cfg_wr) live = int'(cfg_wdata);
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            chk(ce_n === m_ce, "R1/R6 ce_n", ce_n, m_ce);
            chk(busy === !m_ce, "R10 busy", busy, !m_ce);
            chk(out_valid === m_valid, "R3/R4 out_valid", out_valid, m_valid);
            if (m_valid) chk(out_data === m_data, "R3 out_data", out_data, m_data);
            chk(done === m_done, "R7 done", done, m_done);
            if (out_valid) vc++;
            if (done) begin
                chk(vc == s_n, "R5/R9 word count", vc, s_n);
                vc = 0;
            end
        end
    end

    always @(negedge clk) begin
        rd_data <= rd_data + 16'h0113;
        clk_en  <= pause_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic wr_cfg(input int lat, input int ws, input int hold, input int len);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = mk(lat, ws, hold, len);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic go();
        @(negedge clk);
        start = 1'b1;
        do @(negedge clk); while (!m_busy);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R7 watchdog act=hung exp=done");
        summary();
        $finish;
    end

    initial begin
        int ndone;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(ce_n === 1'b1, "R11 ce_n", ce_n, 1);
        chk(busy === 1'b0, "R11 busy", busy, 0);
        chk(out_valid === 1'b0, "R11 out_valid", out_valid, 0);
        chk(done === 1'b0, "R11 done", done, 0);
        rst_n = 1'b1;
        running = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R3";  wr_cfg(0, 1, 0, 0); go();
        tag = "R2";  wr_cfg(7, 0, 1, 1); go();
        tag = "R4";  wr_cfg(3, 2, 1, 2); go();
        tag = "R6";  wr_cfg(1, 3, 0, 0); go();

        tag = "R8";
        pause_mode = 1'b1;
        wr_cfg(2, 3, 1, 3); go();
        wr_cfg(5, 1, 0, 1); go();
        pause_mode = 1'b0;

        // R9: write in the middle of a burst affects only the next one
        tag = "R9";
        wr_cfg(0, 1, 0, 0);
        @(negedge clk);
        start = 1'b1;
        do @(negedge clk); while (!m_busy);
        start = 1'b0;
        while (!out_valid) @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = mk(6, 2, 1, 3);
        @(negedge clk);
        cfg_wr = 1'b0;
        while (!done) @(negedge clk);
        go();

        // R1: write on the accepting edge, start held through release
        tag = "R1";
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = mk(0, 1, 0, 1);
        start = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        ndone = 0;
        while (ndone < 2) begin
            @(negedge clk);
            if (done) ndone++;
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(ce_n === 1'b1, "R1 idle after held start", ce_n, 1);

        running = 1'b0;
        summary();
        $finish;
    end

endmodule